// File: doc/BRIEF.md
# Ripple-Carry Bit-Slice ALU with Signed Compare

This block is a purely combinational arithmetic and logic unit. It is built from identical one-bit slices that pass a ripple carry from each slice to the next. The width is a parameter and defaults to 32 bits. Every slice computes all of its candidate outputs at the same time: the AND, the OR and a full-adder sum. A two-bit operation code is sent unchanged to every slice and picks one of these candidates.

Two inversion lines control the operands. One inverts operand A and the other inverts operand B. The B-inversion line also feeds the carry into slice 0. Together these let one adder perform both addition and subtraction, and let the AND path produce NOR.

The topmost slice holds extra logic. It forms the signed overflow flag and a "set" value that is corrected for overflow. The set value is routed back into the low slice, where it becomes the result of a signed less-than comparison. A zero flag reports an all-zero result. The carry out of the top slice is visible at the ports.

Top module: `alu_ripple`

## Requirements
- R1: With op=2'b00, A-invert=0 and B-invert=0, the result is the bitwise AND of A and B.
- R2: With op=2'b01 and both inversion lines at 0, the result is the bitwise OR of A and B.
- R3: With op=2'b10 and both inversion lines at 0, the result is A+B modulo 2^WIDTH, and carry_o is bit WIDTH of the unsigned sum.
- R4: With op=2'b10, B-invert=1 and A-invert=0, the result is A−B modulo 2^WIDTH, and carry_o is 1 exactly when A ≥ B taken as unsigned numbers.
- R5: With op=2'b00 and both inversion lines at 1, the result is the bitwise NOR of A and B.
- R6: With op=2'b11, B-invert=1 and A-invert=0, result bit 0 is 1 exactly when A < B as signed two's-complement numbers. Every other result bit is 0. This stays correct when A−B overflows.
- R7: For addition and subtraction (op=2'b10), ovf_o is 1 exactly when the signed result does not fit in WIDTH bits.
- R8: zero_o is 1 exactly when every bit of the result is 0, for every operation.
- R9: The inversion lines act on each operand independently. With A-invert=1, B-invert=0 and op=2'b00 the result is (NOT A) AND B. With both inversion lines at 1 and op=2'b01 the result is NOT (A AND B).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| a_inv_i | input | 1 | Invert operand A in every slice |
| b_inv_i | input | 1 | Invert operand B in every slice; also the carry into slice 0 |
| op_i | input | 2 | Operation: 00 AND, 01 OR, 10 sum, 11 less-than |
| result_o | output | WIDTH | Selected result |
| carry_o | output | 1 | Carry out of the most significant slice |
| ovf_o | output | 1 | Signed overflow of the most significant slice |
| zero_o | output | 1 | High when result_o is all zeros |

## Verification
The hardest case to reach is a less-than comparison where the subtraction underneath it overflows. In that case the sign bit of A−B gives the wrong answer, and only the overflow correction in the top slice fixes it.

The stimulus reaches this case by pairing the most negative value with a positive operand, and the most positive value with the most negative one. It does this at the default 32-bit width and again on a second instance with a width of 4, where 1000 minus 0001 is driven directly.

The same edge values also drive the carry into and out of the top slice, which exercises the overflow flag for both addition and subtraction.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [1:0] {
    ALU_OP_AND  = 2'b00,
    ALU_OP_OR   = 2'b01,
    ALU_OP_SUM  = 2'b10,
    ALU_OP_LESS = 2'b11
  } alu_op_e;

  // Output mux shared by every slice: all candidates exist, op picks one.
  function automatic logic alu_pick(input alu_op_e op, input logic and_v,
                                    input logic or_v, input logic sum_v,
                                    input logic less_v);
    logic r;
    unique case (op)
      ALU_OP_AND: r = and_v;
      ALU_OP_OR:  r = or_v;
      ALU_OP_SUM: r = sum_v;
      default:    r = less_v;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/alu_full_adder.sv
module alu_full_adder (
  input  logic x_i,
  input  logic y_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);

  // Sum is high for an odd count of ones among the three inputs.
  always_comb begin
    s_o = x_i ^ y_i ^ c_i;
    c_o = (x_i & y_i) | (x_i & c_i) | (y_i & c_i);
  end

endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
  import alu_pkg::*;
(
  input  logic    a_i,
  input  logic    b_i,
  input  logic    a_inv_i,
  input  logic    b_inv_i,
  input  logic    carry_i,
  input  logic    less_i,
  input  alu_op_e op_i,
  output logic    res_o,
  output logic    carry_o
);

  logic a_sel, b_sel, sum_w;

  always_comb begin
    a_sel = a_inv_i ? ~a_i : a_i;
    b_sel = b_inv_i ? ~b_i : b_i;
  end

  alu_full_adder fa_i (
    .x_i (a_sel),
    .y_i (b_sel),
    .c_i (carry_i),
    .s_o (sum_w),
    .c_o (carry_o)
  );

  always_comb res_o = alu_pick(op_i, a_sel & b_sel, a_sel | b_sel, sum_w, less_i);

endmodule

// File: rtl/alu_top_slice.sv
module alu_top_slice
  import alu_pkg::*;
(
  input  logic    a_i,
  input  logic    b_i,
  input  logic    a_inv_i,
  input  logic    b_inv_i,
  input  logic    carry_i,
  input  logic    less_i,
  input  alu_op_e op_i,
  output logic    res_o,
  output logic    carry_o,
  output logic    ovf_o,
  output logic    set_o
);

  logic a_sel, b_sel, sum_w;

  always_comb begin
    a_sel = a_inv_i ? ~a_i : a_i;
    b_sel = b_inv_i ? ~b_i : b_i;
  end

  alu_full_adder fa_i (
    .x_i (a_sel),
    .y_i (b_sel),
    .c_i (carry_i),
    .s_o (sum_w),
    .c_o (carry_o)
  );

  // Overflow: carry entering the sign slice differs from carry leaving it.
  // Set: sign of the difference, flipped when that sign is known wrong.
  always_comb begin
    ovf_o = carry_i ^ carry_o;
    set_o = sum_w ^ ovf_o;
    res_o = alu_pick(op_i, a_sel & b_sel, a_sel | b_sel, sum_w, less_i);
  end

endmodule

// File: rtl/alu_ripple.sv
module alu_ripple
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             a_inv_i,
  input  logic             b_inv_i,
  input  logic [1:0]       op_i,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_o,
  output logic             ovf_o,
  output logic             zero_o
);

  localparam int MSB = WIDTH - 1;

  alu_op_e          op_w;
  logic [WIDTH:0]   carry_w;
  logic [WIDTH-1:0] less_w;
  logic [WIDTH-1:0] res_w;
  logic             set_w;

  always_comb begin
    op_w       = alu_op_e'(op_i);
    carry_w[0] = b_inv_i;          // +1 of the two's complement for SUB/SLT
    less_w     = '0;
    less_w[0]  = set_w;            // compare result returns to bit 0
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    if (i == MSB) begin : g_top
      alu_top_slice slice_i (
        .a_i     (a_i[i]),
        .b_i     (b_i[i]),
        .a_inv_i (a_inv_i),
        .b_inv_i (b_inv_i),
        .carry_i (carry_w[i]),
        .less_i  (less_w[i]),
        .op_i    (op_w),
        .res_o   (res_w[i]),
        .carry_o (carry_w[i+1]),
        .ovf_o   (ovf_o),
        .set_o   (set_w)
      );
    end else begin : g_low
      alu_bit_slice slice_i (
        .a_i     (a_i[i]),
        .b_i     (b_i[i]),
        .a_inv_i (a_inv_i),
        .b_inv_i (b_inv_i),
        .carry_i (carry_w[i]),
        .less_i  (less_w[i]),
        .op_i    (op_w),
        .res_o   (res_w[i]),
        .carry_o (carry_w[i+1])
      );
    end
  end

  always_comb begin
    result_o = res_w;
    carry_o  = carry_w[WIDTH];
    zero_o   = ~|res_w;
  end

endmodule

// File: rtl/alu_ripple_chk.sv
module alu_ripple_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             a_inv_i,
  input logic             b_inv_i,
  input logic [1:0]       op_i,
  input logic [WIDTH-1:0] result_o,
  input logic             carry_o,
  input logic             ovf_o,
  input logic             zero_o
);

  localparam int M = WIDTH - 1;

  always_comb begin
    if (op_i == 2'b00 && !a_inv_i && !b_inv_i)
      AST_AND_RESULT: assert (result_o == (a_i & b_i)); // R1
    if (op_i == 2'b01 && !a_inv_i && !b_inv_i)
      AST_OR_RESULT: assert (result_o == (a_i | b_i)); // R2
    if (op_i == 2'b10 && !a_inv_i && !b_inv_i)
      AST_ADD_RESULT: assert ({carry_o, result_o} == ({1'b0, a_i} + {1'b0, b_i})); // R3
    if (op_i == 2'b10 && !a_inv_i && b_inv_i)
      AST_SUB_RESULT: assert (result_o == (a_i - b_i) && carry_o == (a_i >= b_i)); // R4
    if (op_i == 2'b00 && a_inv_i && b_inv_i)
      AST_NOR_RESULT: assert (result_o == ~(a_i | b_i)); // R5
    if (op_i == 2'b11 && !a_inv_i && b_inv_i)
      AST_SLT_RESULT: assert (result_o == {{M{1'b0}}, ($signed(a_i) < $signed(b_i))}); // R6
    if (op_i == 2'b10 && !a_inv_i && b_inv_i)
      AST_SUB_OVERFLOW: assert (ovf_o == ((a_i[M] != b_i[M]) && (result_o[M] != a_i[M]))); // R7
    AST_ZERO_FLAG: assert (zero_o == (result_o == '0)); // R8
  end

endmodule

bind alu_ripple alu_ripple_chk #(.WIDTH(WIDTH)) chk_i (
  .a_i      (a_i),
  .b_i      (b_i),
  .a_inv_i  (a_inv_i),
  .b_inv_i  (b_inv_i),
  .op_i     (op_i),
  .result_o (result_o),
  .carry_o  (carry_o),
  .ovf_o    (ovf_o),
  .zero_o   (zero_o)
);

// File: tb/alu_ripple_tb_top.sv
module alu_ripple_tb_top;

  localparam int W  = 32;
  localparam int NV = 16;

  logic clk;
  logic rst_n;
  int   checks;
  int   errors;
  bit   done;

  logic [W-1:0] a, b, res;
  logic         ainv, binv, cy, ovf, zf;
  logic [1:0]   op;

  logic [3:0]   a4, b4, res4;
  logic         ainv4, binv4, cy4, ovf4, zf4;
  logic [1:0]   op4;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;   // 200 MHz

  alu_ripple #(.WIDTH(W)) dut_i (
    .a_i (a), .b_i (b), .a_inv_i (ainv), .b_inv_i (binv), .op_i (op),
    .result_o (res), .carry_o (cy), .ovf_o (ovf), .zero_o (zf)
  );

  alu_ripple #(.WIDTH(4)) dut4_i (
    .a_i (a4), .b_i (b4), .a_inv_i (ainv4), .b_inv_i (binv4), .op_i (op4),
    .result_o (res4), .carry_o (cy4), .ovf_o (ovf4), .zero_o (zf4)
  );

  // Stimulus table; control nibble is {a_inv, b_inv, op[1:0]}.
  localparam logic [W-1:0] TBL_A [NV] = '{
    32'hF0F0_1234, 32'hF0F0_1234, 32'h7FFF_FFFF, 32'hFFFF_FFFF,
    32'h1234_5678, 32'h8000_0000, 32'h0000_0005, 32'h0000_0003,
    32'hA5A5_0000, 32'hFFFF_FFFF, 32'h0000_0000, 32'h8000_0000,
    32'h7FFF_FFFF, 32'h0000_002A, 32'hFFFF_0000, 32'hFF00_FF00};
  localparam logic [W-1:0] TBL_B [NV] = '{
    32'h0FF0_FF00, 32'h0FF0_FF00, 32'h0000_0001, 32'h0000_0001,
    32'h1111_1111, 32'h0000_0001, 32'h0000_0005, 32'h0000_0007,
    32'h0F0F_00FF, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0001,
    32'h8000_0000, 32'h0000_002A, 32'h1234_5678, 32'h0F0F_0F0F};
  localparam logic [3:0] TBL_C [NV] = '{
    4'b0000, 4'b0001, 4'b0010, 4'b0010,
    4'b0010, 4'b0110, 4'b0110, 4'b0110,
    4'b1100, 4'b0111, 4'b0111, 4'b0111,
    4'b0111, 4'b0111, 4'b1000, 4'b1101};

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [3:0] c);
    case (c)
      4'b0000: return "R1 and";
      4'b0001: return "R2 or";
      4'b0010: return "R3 add";
      4'b0110: return "R4 sub";
      4'b1100: return "R5 nor";
      4'b0111: return "R6 slt";
      default: return "R9 inverted operand";
    endcase
  endfunction

  // Behavioural model of the requirements.
  function automatic logic [W-1:0] exp_result(input logic [W-1:0] x, input logic [W-1:0] y,
                                               input logic [3:0] c);
    logic [W-1:0] xa, yb;
    xa = c[3] ? ~x : x;
    yb = c[2] ? ~y : y;
    case (c[1:0])
      2'b00:   return xa & yb;
      2'b01:   return xa | yb;
      2'b10:   return c[2] ? (x - y) : (x + y);
      default: return {{(W-1){1'b0}}, ($signed(x) < $signed(y))};
    endcase
  endfunction

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0;
    a = '0; b = '0; ainv = 1'b0; binv = 1'b0; op = 2'b00;
    a4 = '0; b4 = '0; ainv4 = 1'b0; binv4 = 1'b0; op4 = 2'b00;
    repeat (2) @(negedge clk);
    // Idle state: zero operands under AND give a zero result and zero flag.
    check("R1 idle result", res, '0);
    check("R8 idle zero flag", {31'b0, zf}, 32'd1);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [W:0] full;
      logic       exp_cy, exp_ovf;
      logic [W-1:0] er;
      @(negedge clk);
      a = TBL_A[i]; b = TBL_B[i];
      {ainv, binv, op} = TBL_C[i];
      #1;
      er = exp_result(a, b, TBL_C[i]);
      check(tag_of(TBL_C[i]), res, er);
      check("R8 zero flag", {31'b0, zf}, {31'b0, (er == '0)});
      if (op == 2'b10) begin
        if (binv) begin
          full    = {a[W-1], a} - {b[W-1], b};
          exp_cy  = (a >= b);
          check("R4 carry", {31'b0, cy}, {31'b0, exp_cy});
        end else begin
          full    = {a[W-1], a} + {b[W-1], b};
          exp_cy  = ({1'b0, a} + {1'b0, b}) >> W;
          check("R3 carry", {31'b0, cy}, {31'b0, exp_cy});
        end
        exp_ovf = full[W] != full[W-1];
        check("R7 overflow", {31'b0, ovf}, {31'b0, exp_ovf});
      end
    end

    // Narrow instance: 1000 - 0001 overflows, compare must still say -8 < 1.
    @(negedge clk);
    a4 = 4'b1000; b4 = 4'b0001; ainv4 = 1'b0; binv4 = 1'b1; op4 = 2'b10;
    #1;
    check("R4 w4 sub result", {28'b0, res4}, 32'h7);
    check("R7 w4 sub overflow", {31'b0, ovf4}, 32'd1);
    check("R4 w4 sub carry", {31'b0, cy4}, 32'd1);
    @(negedge clk);
    op4 = 2'b11;
    #1;
    check("R6 w4 slt under overflow", {28'b0, res4}, 32'h1);
    check("R8 w4 slt zero flag", {31'b0, zf4}, 32'd0);
    @(negedge clk);
    a4 = 4'b0001; b4 = 4'b1000;
    #1;
    check("R6 w4 slt reversed", {28'b0, res4}, 32'h0);
    check("R8 w4 zero on false compare", {31'b0, zf4}, 32'd1);
    @(negedge clk);
    a4 = 4'b0111; b4 = 4'b0001; binv4 = 1'b0; op4 = 2'b10;
    #1;
    check("R3 w4 add result", {28'b0, res4}, 32'h8);
    check("R7 w4 add overflow", {31'b0, ovf4}, 32'd1);
    check("R3 w4 add carry", {31'b0, cy4}, 32'd0);
    @(negedge clk);
    a4 = 4'b1111; b4 = 4'b0001;
    #1;
    check("R3 w4 wrap result", {28'b0, res4}, 32'h0);
    check("R3 w4 wrap carry", {31'b0, cy4}, 32'd1);
    check("R7 w4 no overflow", {31'b0, ovf4}, 32'd0);
    check("R8 w4 wrap zero", {31'b0, zf4}, 32'd1);
    @(negedge clk);
    a4 = 4'b1010; b4 = 4'b0110; ainv4 = 1'b1; binv4 = 1'b1; op4 = 2'b00;
    #1;
    check("R5 w4 nor", {28'b0, res4}, 32'h1);
    @(negedge clk);
    op4 = 2'b01;
    #1;
    check("R9 w4 nand", {28'b0, res4}, 32'hD);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule